// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

This block adds two unsigned N-bit operands and a carry-in, producing an N-bit sum and a carry-out, with no clock and no storage. Every column's carry is obtained from a logarithmic-depth tree of prefix cells. Each cell combines a generate/propagate pair for an upper span with the pair for the span just below it. The carry-in is treated as one more column sitting under bit 0, with generate equal to the carry-in and propagate forced low. This means that every carry the tree delivers is simply the generate term of a span reaching down to that extra column.

The operand width is a parameter and must be a power of two of at least 2. A second parameter selects the shape of the tree. The sparse-fanout shape halves the cell count but lets fanout double at each level. The full-parallel shape uses one cell per column per level, and no node drives more than two cells. Both shapes reach every carry in log2(N) levels, with spans doubling from one level to the next. The carry-out is produced by one further merge of the top column with the carry that enters it.

Top module: `pfx_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of the unsigned sum `a_i + b_i + carry_i`.
- R2: `carry_o` equals bit WIDTH (the bit just above the sum) of the unsigned sum `a_i + b_i + carry_i`.
- R3: With `a_i` all ones, `b_i` zero and `carry_i` = 1, the carry crosses every column: `sum_o` is zero and `carry_o` is 1. The same holds for `a_i` all ones plus `b_i` = 1 with `carry_i` = 0.
- R4: When `b_i` is the bitwise complement of `a_i`, `sum_o` is all ones and `carry_o` is 0 for `carry_i` = 0, and `sum_o` is zero and `carry_o` is 1 for `carry_i` = 1.
- R5: With `a_i` zero and `carry_i` = 0, `sum_o` equals `b_i` and `carry_o` is 0. All-zero inputs give an all-zero result.
- R6: When `carry_o` is 1, `sum_o` is not above `a_i` as an unsigned value. When `carry_o` is 0, `sum_o` is not below `a_i`.
- R7: TREE_KIND = 0 (sparse-fanout tree) and TREE_KIND = 1 (full-parallel tree) give identical `sum_o` and `carry_o` for every input.
- R8: The block is correct at every power-of-two WIDTH. This is shown exhaustively at WIDTH = 4 and over random operands at WIDTH = 32. A WIDTH below 2 or not a power of two stops elaboration, as does a TREE_KIND other than 0 or 1.
- R9: The outputs depend only on the present inputs. A change of inputs between clock edges shows on `sum_o` and `carry_o` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum, modulo 2^WIDTH |
| carry_o | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The assertions assume that all three inputs carry known logic values. They skip evaluation while any input bit is unknown, so they are silent before the stimulus first drives the operands. The pattern properties for the full carry chain, complementary operands and the zero operand only fire when the inputs form those patterns. The bench therefore drives every operand to a defined value from time zero and steers directed vectors onto each of those patterns, alongside exhaustive 4-bit and random 32-bit operands.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

   // generate / propagate pair of one span of columns
   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   localparam int TREE_SPARSE = 0;   // fanout-doubling tree, fewest cells
   localparam int TREE_FULL   = 1;   // one cell per column per level

   // upper span i:k combined with lower span k-1:j
   function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
      gp_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pfx_column_pg.sv
module pfx_column_pg
   import pfx_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output gp_t  [W-1:0] leaf_o,   // position 0: carry-in column, position k: bit k-1
   output gp_t          top_o,    // pair of the most significant bit
   output logic [W-1:0] half_o    // a xor b per bit
);

   // column below bit 0 holds the carry-in and never propagates
   assign leaf_o[0] = '{g: cin_i, p: 1'b0};

   for (genvar i = 0; i < W - 1; i++) begin : g_col
      assign leaf_o[i+1] = '{g: a_i[i] & b_i[i], p: a_i[i] | b_i[i]};
   end

   assign top_o  = '{g: a_i[W-1] & b_i[W-1], p: a_i[W-1] | b_i[W-1]};
   assign half_o = a_i ^ b_i;

endmodule

// File: rtl/pfx_tree.sv
module pfx_tree
   import pfx_pkg::*;
#(
   parameter int W    = 32,
   parameter int KIND = TREE_SPARSE
) (
   input  gp_t  [W-1:0] leaf_i,
   output logic [W-1:0] carry_o   // carry_o[k]: generate of span k..0 = carry into bit k
);

   localparam int LVLS = $clog2(W);

   gp_t [W-1:0] node [LVLS+1];

   assign node[0] = leaf_i;

   for (genvar lvl = 0; lvl < LVLS; lvl++) begin : g_lvl
      localparam int SPAN = 1 << lvl;
      for (genvar col = 0; col < W; col++) begin : g_node
         if (KIND == TREE_SPARSE) begin : g_sparse
            if (((col >> lvl) & 1) == 1) begin : g_cell
               localparam int PART = ((col >> lvl) << lvl) - 1;
               assign node[lvl+1][col] = gp_merge(node[lvl][col], node[lvl][PART]);
            end else begin : g_pass
               assign node[lvl+1][col] = node[lvl][col];
            end
         end else begin : g_full
            if (col >= SPAN) begin : g_cell
               assign node[lvl+1][col] = gp_merge(node[lvl][col], node[lvl][col-SPAN]);
            end else begin : g_pass
               assign node[lvl+1][col] = node[lvl][col];
            end
         end
      end
   end

   for (genvar col = 0; col < W; col++) begin : g_out
      assign carry_o[col] = node[LVLS][col].g;
   end

   // every final span reaches the carry-in column, so its propagate is always low
   logic unused_span_p;
   always_comb begin
      unused_span_p = 1'b0;
      for (int c = 0; c < W; c++) unused_span_p = unused_span_p ^ node[LVLS][c].p;
   end

endmodule

// File: rtl/pfx_sum.sv
module pfx_sum
   import pfx_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] half_i,
   input  logic [W-1:0] carry_i,
   input  gp_t          top_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);

   assign sum_o  = half_i ^ carry_i;
   assign cout_o = top_i.g | (top_i.p & carry_i[W-1]);

endmodule

// File: rtl/pfx_adder.sv
module pfx_adder
   import pfx_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int TREE_KIND = TREE_SPARSE
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_o
);

   // R8: reject unsupported parameters at elaboration
   if (WIDTH < 2 || !is_pow2(WIDTH)) begin : g_bad_width
      $error("pfx_adder: WIDTH must be a power of two of at least 2");
   end
   if (TREE_KIND != TREE_SPARSE && TREE_KIND != TREE_FULL) begin : g_bad_kind
      $error("pfx_adder: TREE_KIND must be 0 or 1");
   end

   gp_t  [WIDTH-1:0] leaf;
   gp_t              top_gp;
   logic [WIDTH-1:0] half;
   logic [WIDTH-1:0] carry_in_col;

   pfx_column_pg #(.W(WIDTH)) u_pg (
      .a_i    (a_i),
      .b_i    (b_i),
      .cin_i  (carry_i),
      .leaf_o (leaf),
      .top_o  (top_gp),
      .half_o (half)
   );

   pfx_tree #(.W(WIDTH), .KIND(TREE_KIND)) u_tree (
      .leaf_i  (leaf),
      .carry_o (carry_in_col)
   );

   pfx_sum #(.W(WIDTH)) u_sum (
      .half_i  (half),
      .carry_i (carry_in_col),
      .top_i   (top_gp),
      .sum_o   (sum_o),
      .cout_o  (carry_o)
   );

endmodule

// File: rtl/pfx_adder_chk.sv
module pfx_adder_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic             carry_i,
   input logic [WIDTH-1:0] sum_o,
   input logic             carry_o
);

   logic [WIDTH:0] total;

   always_comb begin
      total = {1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(carry_i);
      if (!$isunknown({a_i, b_i, carry_i})) begin
         // R1
         sum_low_chk: assert (sum_o == total[WIDTH-1:0])
            else $error("sum bits differ from arithmetic sum");
         // R2
         carry_out_chk: assert (carry_o == total[WIDTH])
            else $error("carry-out differs from arithmetic sum");
         // R3
         if ((&a_i) && (b_i == '0) && carry_i) begin
            full_chain_chk: assert ((sum_o == '0) && carry_o)
               else $error("carry did not cross all columns");
         end
         // R4
         if (b_i == ~a_i) begin
            complement_chk: assert ((sum_o == {WIDTH{~carry_i}}) && (carry_o == carry_i))
               else $error("complementary operands gave wrong result");
         end
         // R5
         if ((a_i == '0) && !carry_i) begin
            zero_ident_chk: assert ((sum_o == b_i) && !carry_o)
               else $error("zero operand did not pass other operand");
         end
         // R6
         wrap_order_chk: assert (carry_o ? (sum_o <= a_i) : (sum_o >= a_i))
            else $error("carry-out inconsistent with sum ordering");
      end
   end

endmodule

bind pfx_adder pfx_adder_chk #(.WIDTH(WIDTH)) u_pfx_adder_chk (
   .a_i     (a_i),
   .b_i     (b_i),
   .carry_i (carry_i),
   .sum_o   (sum_o),
   .carry_o (carry_o)
);

// File: tb/test_pfx_adder.sv
module test_pfx_adder;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   int n_chk = 0;
   int n_err = 0;

   logic [31:0] a32 = '0, b32 = '0;
   logic        c32 = 1'b0;
   logic [31:0] s_sp, s_fu;
   logic        co_sp, co_fu;

   logic [3:0]  a4 = '0, b4 = '0;
   logic        c4 = 1'b0;
   logic [3:0]  s4_sp, s4_fu;
   logic        co4_sp, co4_fu;

   pfx_adder #(.WIDTH(32), .TREE_KIND(0)) i_pfx_adder (
      .a_i(a32), .b_i(b32), .carry_i(c32), .sum_o(s_sp), .carry_o(co_sp));
   pfx_adder #(.WIDTH(32), .TREE_KIND(1)) i_pfx_adder_full32 (
      .a_i(a32), .b_i(b32), .carry_i(c32), .sum_o(s_fu), .carry_o(co_fu));
   pfx_adder #(.WIDTH(4), .TREE_KIND(0)) i_pfx_adder_sp4 (
      .a_i(a4), .b_i(b4), .carry_i(c4), .sum_o(s4_sp), .carry_o(co4_sp));
   pfx_adder #(.WIDTH(4), .TREE_KIND(1)) i_pfx_adder_fu4 (
      .a_i(a4), .b_i(b4), .carry_i(c4), .sum_o(s4_fu), .carry_o(co4_fu));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive away from the rising edge, then let the logic settle
   task automatic drive32(input logic [31:0] a, input logic [31:0] b, input logic c);
      @(negedge clk);
      a32 = a; b32 = b; c32 = c;
      #2;
   endtask

   // R1 R2 R7: both 32-bit trees against behavioural addition
   task automatic check32(input string tag);
      logic [32:0] exp;
      exp = {1'b0, a32} + {1'b0, b32} + {32'b0, c32};
      chk({tag, " R1/R2 sparse"}, {31'b0, co_sp, s_sp}, {31'b0, exp});
      chk({tag, " R7 full"},      {31'b0, co_fu, s_fu}, {31'b0, exp});
   endtask

   task automatic t_reset_state;
      drive32('0, '0, 1'b0);
      chk("R5 all-zero sum", {32'b0, s_sp}, 64'd0);
      chk("R5 all-zero carry", {63'b0, co_sp}, 64'd0);
   endtask

   task automatic t_ones_plus_one;
      drive32(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
      chk("R3 ones+1 sum", {32'b0, s_sp}, 64'd0);
      chk("R3 ones+1 carry", {63'b0, co_sp}, 64'd1);
      check32("R3 ones+1");
      drive32(32'hFFFF_FFFF, 32'h0, 1'b1);
      chk("R3 ones+cin sum", {32'b0, s_sp}, 64'd0);
      chk("R3 ones+cin carry", {63'b0, co_sp}, 64'd1);
      check32("R3 ones+cin");
      drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
      chk("R2 max+max+1", {31'b0, co_sp, s_sp}, {31'b0, 1'b1, 32'hFFFF_FFFF});
   endtask

   task automatic t_alternating;
      for (int c = 0; c < 2; c++) begin
         drive32(32'hAAAA_AAAA, 32'h5555_5555, c[0]);
         chk("R4 alt complement", {31'b0, co_sp, s_sp},
             (c == 0) ? {31'b0, 1'b0, 32'hFFFF_FFFF} : {31'b0, 1'b1, 32'h0});
         check32("R4 alt");
         drive32(32'hAAAA_AAAA, 32'hAAAA_AAAA, c[0]);
         check32("R1 alt same");
         drive32(32'h5555_5555, 32'h5555_5555, c[0]);
         check32("R1 alt low");
      end
   endtask

   task automatic t_complement;
      drive32(32'h1234_5678, ~32'h1234_5678, 1'b0);
      chk("R4 cin0", {31'b0, co_sp, s_sp}, {31'b0, 1'b0, 32'hFFFF_FFFF});
      drive32(32'h1234_5678, ~32'h1234_5678, 1'b1);
      chk("R4 cin1", {31'b0, co_sp, s_sp}, {31'b0, 1'b1, 32'h0});
   endtask

   task automatic t_zero_identity;
      drive32(32'h0, 32'hDEAD_BEEF, 1'b0);
      chk("R5 identity", {31'b0, co_sp, s_sp}, {31'b0, 1'b0, 32'hDEAD_BEEF});
   endtask

   task automatic t_ordering;
      drive32(32'h8000_0000, 32'h8000_0001, 1'b0);
      chk("R6 wrap carry", {63'b0, co_sp}, 64'd1);
      chk("R6 wrap below a", {63'b0, (s_sp <= a32)}, 64'd1);
      drive32(32'h0000_1000, 32'h0000_0FFF, 1'b1);
      chk("R6 no wrap", {63'b0, co_sp}, 64'd0);
      chk("R6 not below a", {63'b0, (s_sp >= a32)}, 64'd1);
   endtask

   // R8: every 4-bit input on both trees
   task automatic t_exhaustive4;
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            for (int c = 0; c < 2; c++) begin
               logic [4:0] exp;
               @(negedge clk);
               a4 = a[3:0]; b4 = b[3:0]; c4 = c[0];
               #2;
               exp = {1'b0, a4} + {1'b0, b4} + {4'b0, c4};
               chk("R8 w4 sparse", {59'b0, co4_sp, s4_sp}, {59'b0, exp});
               chk("R8 w4 full",   {59'b0, co4_fu, s4_fu}, {59'b0, exp});
            end
         end
      end
   endtask

   task automatic t_random32;
      for (int k = 0; k < 3000; k++) begin
         drive32($urandom, $urandom, 1'($urandom));
         check32("R8 w32 random");
      end
   endtask

   // R9: input change between edges shows without a clock edge
   task automatic t_no_clock;
      logic [32:0] exp;
      @(posedge clk);
      #3;
      a32 = 32'h0F0F_0F0F; b32 = 32'hF0F0_F0F1; c32 = 1'b0;
      #1;
      exp = {1'b0, a32} + {1'b0, b32};
      chk("R9 same-step update", {31'b0, co_sp, s_sp}, {31'b0, exp});
      #1;
      b32 = 32'h0000_0001;
      #1;
      exp = {1'b0, a32} + 33'd1;
      chk("R9 second update", {31'b0, co_sp, s_sp}, {31'b0, exp});
   endtask

   initial begin
      repeat (2) @(posedge clk);
      t_reset_state();
      t_ones_plus_one();
      t_alternating();
      t_complement();
      t_zero_identity();
      t_ordering();
      t_no_clock();
      t_exhaustive4();
      t_random32();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule